// File: doc/BRIEF.md
# Three-Bit-Code ALU with Set-Less-Than

This block is a purely combinational arithmetic and logic unit of configurable width (32 bits by default). It takes two operands and a three-bit function code. It returns a result word and the carry out of its internal adder. The top bit of the code does two jobs at once. It inverts the second operand before that operand reaches both the logic gates and the adder, and it also feeds the adder's carry input. With that bit set, the unit gives AND-with-complement, OR-with-complement, two's-complement subtraction and a signed-style less-than test, all from one adder and one set of gates.

The low two bits of the code choose what reaches the result: the bitwise AND, the bitwise OR, the adder sum, or the sign bit of the sum zero-extended to full width. That last choice is the set-less-than result. Code 011 has no operation and yields zero. The adder structure is chosen by a parameter: a ripple chain or a logarithmic-depth parallel prefix tree. Both give bit-identical results.

Top module: `slt_alu`

## Requirements
- R1: Code 000 returns the bitwise AND of the two operands.
- R2: Code 001 returns the bitwise OR of the two operands.
- R3: Code 010 returns the sum of the operands modulo 2^WIDTH.
- R4: Code 100 returns operand A ANDed with the bitwise complement of operand B.
- R5: Code 101 returns operand A ORed with the bitwise complement of operand B.
- R6: Code 110 returns A minus B modulo 2^WIDTH, formed as A plus the complement of B plus a carry-in of one.
- R7: Code 111 returns a word whose bit 0 is bit WIDTH-1 of (A minus B) and whose other bits are zero. No overflow correction is made, so A=25, B=32 gives 1 and A=0x7FFFFFFF, B=0x80000000 gives 1.
- R8: Code 011 returns an all-zero result word.
- R9: For every code, the carry output is the adder's carry out of bit WIDTH-1. The adder adds A, either B (when code bit 2 is 0) or the complement of B (when code bit 2 is 1), and a carry-in equal to code bit 2.
- R10: The result and carry output depend only on the present inputs. They are valid before the next clock edge after an input change and stay unchanged across clock edges while the inputs are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand, inverted when code bit 2 is set |
| f | input | 3 | Function code |
| y | output | WIDTH | Result word |
| cout | output | 1 | Carry out of the internal adder |

## Verification
Every result of this block is due in the same cycle as its stimulus, with zero register stages on the path. The bench therefore changes operands and code on the falling clock edge and reads the result and carry a few nanoseconds later, well before the next rising edge. For R10 it reads the same outputs again after two further rising edges with the inputs held, and expects them to be unchanged. The expected values come from a wide-integer model of the code table. This model, including the raw sign for set-less-than, is run over a table of hand-worked vectors, all code and edge-value combinations, and random operands.

// File: rtl/slt_alu_pkg.sv
package slt_alu_pkg;

    typedef enum logic [2:0] {
        OP_AND  = 3'b000,
        OP_OR   = 3'b001,
        OP_ADD  = 3'b010,
        OP_NONE = 3'b011,
        OP_ANDN = 3'b100,
        OP_ORN  = 3'b101,
        OP_SUB  = 3'b110,
        OP_SLT  = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        PICK_AND  = 2'b00,
        PICK_OR   = 2'b01,
        PICK_SUM  = 2'b10,
        PICK_SIGN = 2'b11
    } pick_e;

    typedef enum int {
        ADDER_RIPPLE = 0,
        ADDER_PREFIX = 1
    } adder_kind_e;

    typedef struct packed {
        logic  invert_b;
        logic  carry_in;
        pick_e pick;
        logic  force_zero;
    } ctrl_t;

    function automatic ctrl_t decode_code(input logic [2:0] code);
        ctrl_t c;
        c.invert_b   = code[2];
        c.carry_in   = code[2];
        c.pick       = pick_e'(code[1:0]);
        c.force_zero = (code == OP_NONE);
        return c;
    endfunction

endpackage

// File: rtl/slt_alu_decode.sv
module slt_alu_decode
    import slt_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [2:0]       f,
    input  logic [WIDTH-1:0] b,
    output ctrl_t            ctrl,
    output logic [WIDTH-1:0] b_eff
);

    always_comb begin
        ctrl  = decode_code(f);
        b_eff = ctrl.invert_b ? ~b : b;
    end

endmodule

// File: rtl/slt_alu_adder.sv
module slt_alu_adder
    import slt_alu_pkg::*;
#(
    parameter int WIDTH      = 32,
    parameter int ADDER_KIND = ADDER_PREFIX
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] z,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    logic [WIDTH-1:0] half;
    logic [WIDTH:0]   carry;

    assign half = x ^ z;

    generate
        if (ADDER_KIND == ADDER_RIPPLE) begin : g_ripple
            assign carry[0] = cin;
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                assign carry[i+1] = (x[i] & z[i]) | (half[i] & carry[i]);
            end
        end else begin : g_prefix
            logic [LEVELS:0][WIDTH-1:0] gen;
            logic [LEVELS:0][WIDTH-1:0] prop;
            // column 0 absorbs the carry-in so each group generate is a final carry
            assign gen[0][0]  = (x[0] & z[0]) | (half[0] & cin);
            assign prop[0][0] = 1'b0;
            for (genvar i = 1; i < WIDTH; i++) begin : g_init
                assign gen[0][i]  = x[i] & z[i];
                assign prop[0][i] = half[i];
            end
            for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
                localparam int DIST = 1 << l;
                for (genvar i = 0; i < WIDTH; i++) begin : g_col
                    if (i >= DIST) begin : g_merge
                        assign gen[l+1][i]  = gen[l][i] | (prop[l][i] & gen[l][i-DIST]);
                        assign prop[l+1][i] = prop[l][i] & prop[l][i-DIST];
                    end else begin : g_pass
                        assign gen[l+1][i]  = gen[l][i];
                        assign prop[l+1][i] = prop[l][i];
                    end
                end
            end
            assign carry[0] = cin;
            for (genvar i = 1; i <= WIDTH; i++) begin : g_carry
                assign carry[i] = gen[LEVELS][i-1];
            end
        end
    endgenerate

    assign sum  = half ^ carry[WIDTH-1:0];
    assign cout = carry[WIDTH];

    always_comb begin
        AST_SUM_EXACT: assert ({cout, sum} ==
                               ({1'b0, x} + {1'b0, z} + {{WIDTH{1'b0}}, cin}))
            else $error("adder result disagrees with integer sum"); // R3 R6 R9
    end

endmodule

// File: rtl/slt_alu_resmux.sv
module slt_alu_resmux
    import slt_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  ctrl_t            ctrl,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b_eff,
    input  logic [WIDTH-1:0] sum,
    output logic [WIDTH-1:0] y
);

    logic [WIDTH-1:0] and_w;
    logic [WIDTH-1:0] or_w;
    logic [WIDTH-1:0] sign_w;

    assign and_w  = a & b_eff;
    assign or_w   = a | b_eff;
    assign sign_w = {{(WIDTH-1){1'b0}}, sum[WIDTH-1]};

    always_comb begin
        if (ctrl.force_zero) begin
            y = '0;
        end else begin
            unique case (ctrl.pick)
                PICK_AND:  y = and_w;
                PICK_OR:   y = or_w;
                PICK_SUM:  y = sum;
                PICK_SIGN: y = sign_w;
                default:   y = '0;
            endcase
        end
    end

    always_comb begin
        AST_UNUSED_ZERO: assert (!ctrl.force_zero || y == '0)
            else $error("unused code gave a nonzero result"); // R8
        AST_SLT_ZEXT: assert (!(ctrl.pick == PICK_SIGN && !ctrl.force_zero) ||
                              (y[WIDTH-1:1] == '0 && y[0] == sum[WIDTH-1]))
            else $error("set-less-than result malformed"); // R7
        AST_AND_SUBSET: assert (ctrl.pick != PICK_AND || (y & ~a) == '0)
            else $error("AND result sets a bit absent from A"); // R1
        AST_OR_SUPERSET: assert (ctrl.pick != PICK_OR || (a & ~y) == '0)
            else $error("OR result drops a bit of A"); // R2
    end

endmodule

// File: rtl/slt_alu.sv
module slt_alu
    import slt_alu_pkg::*;
#(
    parameter int WIDTH      = 32,
    parameter int ADDER_KIND = ADDER_PREFIX
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [2:0]       f,
    output logic [WIDTH-1:0] y,
    output logic             cout
);

    ctrl_t            ctrl;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] sum;

    slt_alu_decode #(.WIDTH(WIDTH)) u_decode (
        .f     (f),
        .b     (b),
        .ctrl  (ctrl),
        .b_eff (b_eff)
    );

    slt_alu_adder #(.WIDTH(WIDTH), .ADDER_KIND(ADDER_KIND)) u_adder (
        .x    (a),
        .z    (b_eff),
        .cin  (ctrl.carry_in),
        .sum  (sum),
        .cout (cout)
    );

    slt_alu_resmux #(.WIDTH(WIDTH)) u_resmux (
        .ctrl  (ctrl),
        .a     (a),
        .b_eff (b_eff),
        .sum   (sum),
        .y     (y)
    );

    always_comb begin
        AST_SUB_SIGN: assert (f != 3'b111 || y[0] == sum[WIDTH-1])
            else $error("set-less-than bit differs from difference sign"); // R7
    end

endmodule

// File: tb/slt_alu_test.sv
`timescale 1ns/1ps
module slt_alu_test;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a, b, y;
    logic [2:0]   f;
    logic         cout;
    int           n_checks = 0;
    int           n_fail   = 0;
    bit           done     = 1'b0;

    always #5 clk = ~clk;

    slt_alu #(.WIDTH(W)) uut (.a(a), .b(b), .f(f), .y(y), .cout(cout));

    // each row: code, A, B, expected Y, expected carry
    localparam int NV = 13;
    localparam logic [3+W+W+W+1-1:0] VEC [NV] = '{
        {3'b000, 32'h0000000C, 32'h0000000A, 32'h00000008, 1'b0},
        {3'b001, 32'h0000000C, 32'h0000000A, 32'h0000000E, 1'b0},
        {3'b010, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1},
        {3'b100, 32'h0000000C, 32'h0000000A, 32'h00000004, 1'b1},
        {3'b101, 32'h0000000C, 32'h0000000A, 32'hFFFFFFFD, 1'b1},
        {3'b110, 32'h00000019, 32'h00000020, 32'hFFFFFFF9, 1'b0},
        {3'b111, 32'h00000019, 32'h00000020, 32'h00000001, 1'b0},
        {3'b111, 32'h00000020, 32'h00000019, 32'h00000000, 1'b1},
        {3'b111, 32'h80000000, 32'h00000001, 32'h00000000, 1'b1},
        {3'b011, 32'h12345678, 32'h9ABCDEF0, 32'h00000000, 1'b0},
        {3'b110, 32'h00000000, 32'h00000000, 32'h00000000, 1'b1},
        {3'b010, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0},
        {3'b111, 32'h7FFFFFFF, 32'h80000000, 32'h00000001, 1'b0}
    };

    function automatic string req_of(input logic [2:0] code);
        case (code)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R3";
            3'b100: return "R4";
            3'b101: return "R5";
            3'b110: return "R6";
            3'b111: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [W:0] model(input logic [2:0] code,
                                         input logic [W-1:0] x,
                                         input logic [W-1:0] z);
        logic [W-1:0] zz;
        logic [W:0]   s;
        logic [W-1:0] r;
        zz = code[2] ? ~z : z;
        s  = {1'b0, x} + {1'b0, zz} + {{W{1'b0}}, code[2]};
        case (code[1:0])
            2'b00: r = x & zz;
            2'b01: r = x | zz;
            2'b10: r = s[W-1:0];
            default: r = code[2] ? {{(W-1){1'b0}}, s[W-1]} : '0;
        endcase
        return {s[W], r};
    endfunction

    task automatic check(input string tag, input logic [W-1:0] ey, input logic ec);
        n_checks++;
        if (y !== ey) begin
            n_fail++;
            $display("FAIL %s f=%b a=%h b=%h y=%h expected %h", tag, f, a, b, y, ey);
        end
        n_checks++;
        if (cout !== ec) begin
            n_fail++;
            $display("FAIL R9 (%s) f=%b a=%h b=%h cout=%b expected %b", tag, f, a, b, cout, ec);
        end
    endtask

    task automatic apply(input logic [2:0] code, input logic [W-1:0] x, input logic [W-1:0] z);
        @(negedge clk);
        f = code;
        a = x;
        b = z;
        #2;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] edges [4];
        logic [W:0]   exp_v;
        edges = '{32'h00000000, 32'h00000001, 32'hFFFFFFFF, 32'h80000000};
        a = '0; b = '0; f = 3'b000;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // reset-time inputs all zero, code 000: zero result, no carry
        apply(3'b000, '0, '0);
        check("R1 reset inputs", '0, 1'b0);

        // hand-worked vector table
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][3*W+3:3*W+1], VEC[i][3*W:2*W+1], VEC[i][2*W:W+1]);
            check(req_of(VEC[i][3*W+3:3*W+1]), VEC[i][W:1], VEC[i][0]);
        end

        // every code against every pair of edge values
        for (int c = 0; c < 8; c++) begin
            for (int i = 0; i < 4; i++) begin
                for (int j = 0; j < 4; j++) begin
                    apply(3'(c), edges[i], edges[j]);
                    exp_v = model(3'(c), edges[i], edges[j]);
                    check(req_of(3'(c)), exp_v[W-1:0], exp_v[W]);
                end
            end
        end

        // random operands for every code
        for (int k = 0; k < 400; k++) begin
            logic [2:0]   rc;
            logic [W-1:0] ra, rb;
            rc = 3'(k % 8);
            ra = $urandom();
            rb = (k % 5 == 0) ? ra : $urandom();
            apply(rc, ra, rb);
            exp_v = model(rc, ra, rb);
            check(req_of(rc), exp_v[W-1:0], exp_v[W]);
        end

        // R10: outputs hold across clock edges with inputs held
        apply(3'b110, 32'h00000005, 32'h00000009);
        check("R10 settle", 32'hFFFFFFFC, 1'b0);
        repeat (2) @(posedge clk);
        #2;
        check("R10 held", 32'hFFFFFFFC, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule